// File: doc/BRIEF.md
# Split-Access 64-bit Microsecond Timer

This block keeps a free-running 64-bit time count that advances by one on every cycle in which a 1 µs tick strobe is high. Software reaches the count through a small register bus that carries 32-bit words. The low word and the high word sit at separate addresses. A third address holds a single control bit that requests a clear of the count. Beacon-scheduling logic gets a coarse 16-bit time in 1024 µs units as a plain output. A direct load port lets adjustment logic force the count to a new value in one cycle.

Software cannot access 64 bits at once, so the block keeps both halves coherent. A read of the low word captures the high word at the same instant, and the next high-word read returns that captured copy. A write of the low word waits in a holding register until the high word arrives, and then all 64 bits change together.

The clear request is a toggle. Each write of a one to the control bit flips an internal request flag. Only the flip that sets the flag clears the count, so software writes the bit twice to leave the flag clear. A flag that stays set is acted on later by the chip re-initialisation strobe.

Top module: `sync_timer64`

## Requirements
- R1: After reset the count is zero, `tu_out` is zero, no read response is pending, `req_ready` is high and the clear-request flag (bit 0 of address 2) reads as zero.
- R2: In a cycle where `tick_us` is high and no load, bus write or re-initialisation occurs, the count increases by exactly one. With `tick_us` low and nothing else active, the count holds.
- R3: When `load_valid` is high, the count takes `load_value` on the next edge, even if `tick_us` is also high in that cycle.
- R4: A write to address 0 (low word) does not change the count. A later write to address 1 loads the count with {written high word, held low word} in one cycle, and any tick in that cycle is discarded.
- R5: A write to address 1 with no low word held keeps the live low half and replaces only the high half.
- R6: A read of address 0 returns count[31:0] and captures count[63:32]. The next read of address 1 returns the captured word and releases the capture. A read of address 1 with no capture pending returns the live high half.
- R7: A write to address 2 with bit 0 set flips the clear-request flag, and a write with bit 0 clear has no effect. A flip from 0 to 1 clears the count to zero, and a flip from 1 to 0 leaves the count alone. A read of address 2 returns the flag in bit 0 and zeros elsewhere.
- R8: A `chip_reinit` pulse while the flag is set clears both the count and the flag. A pulse while the flag is clear changes nothing.
- R9: `tu_out` equals count[25:10] at every cycle.
- R10: A request is taken on an edge where `req_valid` and `req_ready` are both high. A read's response appears with `rsp_valid` after that edge and holds with stable `rsp_rdata` until an edge with `rsp_ready` high. `req_ready` is low while a response waits without `rsp_ready`.
- R11: A clear (from R7 or R8) takes priority over a bus load, an external load and a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe per microsecond |
| chip_reinit | input | 1 | Re-initialisation strobe; applies a pending clear request |
| load_valid | input | 1 | Force the count to `load_value` |
| load_value | input | 64 | Value for the external load |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | 0 low word, 1 high word, 2 control |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_rdata | output | 32 | Read data |
| tu_out | output | 16 | Count in 1024 µs units |

## Verification
Every state change lands on the edge that accepts its cause. A tick, a load, a committed high-word write or a clear shows in the count, and so in `tu_out`, from the next falling edge on. A read's data is the count as it stood just before the accepting edge and is valid after that edge. The bench drives every input on falling edges and samples one falling edge after the accepting edge. Tests that depend on timing, such as the coherent read across a low-to-high carry, start the tick and the read on the same falling edge, so the expected words follow from the tick count alone.

// File: rtl/stt_pkg.sv
package stt_pkg;

  typedef enum logic [1:0] {
    ADDR_LO  = 2'd0,
    ADDR_HI  = 2'd1,
    ADDR_CTL = 2'd2
  } stt_addr_e;

  // One-hot decode of an accepted bus request
  typedef struct packed {
    logic wr_lo;
    logic wr_hi;
    logic wr_ctl;
    logic rd_lo;
    logic rd_hi;
    logic rd_ctl;
  } stt_op_t;

endpackage

// File: rtl/stt_regif.sv
module stt_regif
  import stt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic              ctl_bit,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              chip_reinit,
  input  logic [DATA_W-1:0] lo_rdata,
  input  logic [DATA_W-1:0] hi_rdata,
  output stt_op_t           op,
  output logic              soft_clr,
  output logic              rst_req
);

  logic fire;
  logic ctl_flip;
  logic reinit_hit;
  logic [DATA_W-1:0] rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  always_comb begin
    op = '0;
    if (fire) begin
      unique case (req_addr)
        ADDR_LO:  if (req_write) op.wr_lo  = 1'b1; else op.rd_lo  = 1'b1;
        ADDR_HI:  if (req_write) op.wr_hi  = 1'b1; else op.rd_hi  = 1'b1;
        ADDR_CTL: if (req_write) op.wr_ctl = 1'b1; else op.rd_ctl = 1'b1;
        default:  op = '0;
      endcase
    end
  end

  assign ctl_flip   = op.wr_ctl && ctl_bit;
  assign reinit_hit = chip_reinit && rst_req;
  // Clear on a 0->1 flip of the request, or when re-init finds it pending
  assign soft_clr   = (ctl_flip && !rst_req) || reinit_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rst_req <= 1'b0;
    else if (reinit_hit) rst_req <= 1'b0;
    else if (ctl_flip)   rst_req <= !rst_req;
  end

  always_comb begin
    rd_mux = '0;
    if (op.rd_lo)       rd_mux = lo_rdata;
    else if (op.rd_hi)  rd_mux = hi_rdata;
    else if (op.rd_ctl) rd_mux[0] = rst_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (fire && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/stt_split.sv
module stt_split
  import stt_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stt_op_t           op,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] hi_rdata,
  output logic              commit,
  output logic [CNT_W-1:0]  commit_val
);

  logic [DATA_W-1:0] shadow_hi;
  logic              shadow_vld;
  logic [DATA_W-1:0] hold_lo;
  logic              hold_vld;

  assign hi_rdata = shadow_vld ? shadow_hi : cnt[CNT_W-1:DATA_W];

  // Read side: low read snapshots the high half for the following high read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_hi  <= '0;
      shadow_vld <= 1'b0;
    end else if (op.rd_lo) begin
      shadow_hi  <= cnt[CNT_W-1:DATA_W];
      shadow_vld <= 1'b1;
    end else if (op.rd_hi) begin
      shadow_vld <= 1'b0;
    end
  end

  // Write side: low word parks here until the high word completes the pair
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_lo  <= '0;
      hold_vld <= 1'b0;
    end else if (op.wr_lo) begin
      hold_lo  <= wdata;
      hold_vld <= 1'b1;
    end else if (op.wr_hi) begin
      hold_vld <= 1'b0;
    end
  end

  assign commit     = op.wr_hi;
  assign commit_val = {wdata, (hold_vld ? hold_lo : cnt[DATA_W-1:0])};

endmodule

// File: rtl/stt_counter.sv
module stt_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sw_ld,
  input  logic [CNT_W-1:0] sw_val,
  input  logic             ext_ld,
  input  logic [CNT_W-1:0] ext_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);

  // Priority: clear, software load, external load, tick
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (sw_ld)  cnt <= sw_val;
    else if (ext_ld) cnt <= ext_val;
    else if (tick)   cnt <= cnt + CNT_W'(1);
  end

endmodule

// File: rtl/sync_timer64.sv
module sync_timer64
  import stt_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TU_SHIFT = 10,
  parameter int TU_W     = 16,
  localparam int CNT_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              chip_reinit,
  input  logic              load_valid,
  input  logic [CNT_W-1:0]  load_value,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [TU_W-1:0]   tu_out
);

  stt_op_t           op;
  logic              soft_clr;
  logic              rst_req_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] hi_rdata;
  logic              commit;
  logic [CNT_W-1:0]  commit_val;

  stt_regif #(.DATA_W(DATA_W)) u_regif (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .ctl_bit(req_wdata[0]),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .chip_reinit(chip_reinit),
    .lo_rdata(cnt_q[DATA_W-1:0]), .hi_rdata(hi_rdata),
    .op(op), .soft_clr(soft_clr), .rst_req(rst_req_q)
  );

  stt_split #(.DATA_W(DATA_W)) u_split (
    .clk(clk), .rst_n(rst_n), .op(op), .wdata(req_wdata), .cnt(cnt_q),
    .hi_rdata(hi_rdata), .commit(commit), .commit_val(commit_val)
  );

  stt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr),
    .sw_ld(commit), .sw_val(commit_val),
    .ext_ld(load_valid), .ext_val(load_value),
    .tick(tick_us), .cnt(cnt_q)
  );

  generate
    if (TU_SHIFT + TU_W <= CNT_W) begin : g_tu_fit
      assign tu_out = cnt_q[TU_SHIFT +: TU_W];
    end else begin : g_tu_pad
      localparam int AVAIL = CNT_W - TU_SHIFT;
      assign tu_out = {{(TU_W - AVAIL){1'b0}}, cnt_q[CNT_W-1:TU_SHIFT]};
    end
  endgenerate

endmodule

// File: rtl/stt_checker.sv
module stt_checker #(
  parameter int DATA_W = 32,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_us,
  input logic              chip_reinit,
  input logic              load_valid,
  input logic [CNT_W-1:0]  load_value,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [1:0]        req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [CNT_W-1:0]  cnt,
  input logic              rst_req
);

  logic wr_fire;
  assign wr_fire = req_valid && req_ready && req_write;

  // R2
  tick_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_us && !load_valid && !wr_fire && !chip_reinit) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_us && !load_valid && !wr_fire && !chip_reinit) |=> $stable(cnt));

  // R3
  ext_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && !wr_fire && !chip_reinit) |=> (cnt == $past(load_value)));

  // R7
  flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && req_addr == 2'd2 && req_wdata[0] && !chip_reinit) |=> (rst_req != $past(rst_req)));

  // R8
  reinit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_reinit && rst_req) |=> (cnt == '0 && !rst_req));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R10
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

endmodule

bind sync_timer64 stt_checker #(.DATA_W(DATA_W)) u_stt_checker (
  .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .chip_reinit(chip_reinit),
  .load_valid(load_valid), .load_value(load_value),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .cnt(cnt_q), .rst_req(rst_req_q)
);

// File: tb/sync_timer64_bench.sv
module sync_timer64_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_us = 1'b0;
  logic        chip_reinit = 1'b0;
  logic        load_valid = 1'b0;
  logic [63:0] load_value = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [15:0] tu_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sync_timer64 u_sync_timer64 (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .chip_reinit(chip_reinit),
    .load_valid(load_valid), .load_value(load_value),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .tu_out(tu_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    while (!req_ready) @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    while (!req_ready) @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic write64(input logic [63:0] v);
    bus_write(2'd0, v[31:0]);
    bus_write(2'd1, v[63:32]);
  endtask

  task automatic read64(output logic [63:0] v);
    logic [31:0] lo, hi;
    bus_read(2'd0, lo);
    bus_read(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic t_reset_state();
    logic [63:0] v; logic [31:0] c;
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    chk("R1 tu_out", 64'(tu_out), 64'd0);
    read64(v);
    chk("R1 count", v, 64'd0);
    bus_read(2'd2, c);
    chk("R1 flag", 64'(c), 64'd0);
  endtask

  task automatic t_tick();
    logic [63:0] v;
    write64(64'h10);
    @(negedge clk); tick_us = 1'b1;
    repeat (7) @(negedge clk);
    tick_us = 1'b0;
    read64(v);
    chk("R2 seven ticks", v, 64'h17);
    // alternating tick pattern: 3 high cycles out of 6
    for (int i = 0; i < 6; i++) begin
      tick_us = (i % 2 == 0);
      @(negedge clk);
    end
    tick_us = 1'b0;
    read64(v);
    chk("R2 sparse ticks", v, 64'h1A);
    repeat (5) @(negedge clk);
    read64(v);
    chk("R2 idle hold", v, 64'h1A);
  endtask

  task automatic t_ext_load();
    logic [63:0] v;
    @(negedge clk);
    load_valid = 1'b1; load_value = 64'hDEAD_BEEF_0123_4567; tick_us = 1'b1;
    @(negedge clk);
    load_valid = 1'b0; tick_us = 1'b0;
    chk("R9 tu after load", 64'(tu_out), 64'(load_value[25:10]));
    read64(v);
    chk("R3 load beats tick", v, 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic t_split_write();
    logic [63:0] v;
    write64(64'h0000_0005_1234_5678);
    bus_write(2'd0, 32'hAAAA_5555);
    read64(v);
    chk("R4 low write held", v, 64'h0000_0005_1234_5678);
    @(negedge clk); tick_us = 1'b1;
    bus_write(2'd1, 32'h3);
    tick_us = 1'b0;
    read64(v);
    // one extra tick at the request-setup edge before the commit edge
    chk("R4 pair commit", v, 64'h0000_0003_AAAA_5555);
    bus_write(2'd1, 32'h9);
    read64(v);
    chk("R5 high only", v, 64'h0000_0009_AAAA_5555);
    chk("R9 tu", 64'(tu_out), 64'(v[25:10]));
  endtask

  task automatic t_coherent_read();
    logic [31:0] lo, hi, hi2;
    write64(64'h0000_0001_FFFF_FFFE);
    @(negedge clk);
    tick_us = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 2'd0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lo = rsp_rdata;
    bus_read(2'd1, hi);
    tick_us = 1'b0;
    chk("R6 low word", 64'(lo), 64'hFFFF_FFFE);
    chk("R6 captured high", 64'(hi), 64'h1);
    bus_read(2'd1, hi2);
    chk("R6 live high", 64'(hi2), 64'h2);
  endtask

  task automatic t_clear_toggle();
    logic [63:0] v; logic [31:0] c;
    write64(64'h0000_0042_0000_1000);
    bus_write(2'd2, 32'h0);
    bus_read(2'd2, c);
    chk("R7 bit0 clear no flip", 64'(c), 64'd0);
    read64(v);
    chk("R7 bit0 clear keeps count", v, 64'h0000_0042_0000_1000);
    // clear plus external load plus tick in one cycle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 2'd2; req_wdata = 32'h1;
    load_valid = 1'b1; load_value = 64'h77; tick_us = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; load_valid = 1'b0; tick_us = 1'b0;
    read64(v);
    chk("R11 clear wins", v, 64'd0);
    bus_read(2'd2, c);
    chk("R7 flag set", 64'(c), 64'd1);
    write64(64'h55);
    bus_write(2'd2, 32'h1);
    bus_read(2'd2, c);
    chk("R7 flag cleared", 64'(c), 64'd0);
    read64(v);
    chk("R7 second flip keeps count", v, 64'h55);
  endtask

  task automatic t_reinit();
    logic [63:0] v; logic [31:0] c;
    @(negedge clk); chip_reinit = 1'b1;
    @(negedge clk); chip_reinit = 1'b0;
    read64(v);
    chk("R8 reinit no pending", v, 64'h55);
    bus_write(2'd2, 32'h1);
    write64(64'h1234);
    @(negedge clk); chip_reinit = 1'b1;
    @(negedge clk); chip_reinit = 1'b0;
    read64(v);
    chk("R8 reinit pending clears", v, 64'd0);
    bus_read(2'd2, c);
    chk("R8 flag released", 64'(c), 64'd0);
  endtask

  task automatic t_backpressure();
    logic [31:0] first, hi;
    write64(64'h0000_0008_CAFE_0001);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 2'd0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    first = rsp_rdata;
    chk("R10 rsp valid", 64'(rsp_valid), 64'd1);
    chk("R10 ready low", 64'(req_ready), 64'd0);
    repeat (3) @(negedge clk);
    chk("R10 held valid", 64'(rsp_valid), 64'd1);
    chk("R10 held data", 64'(rsp_rdata), 64'(first));
    chk("R10 data", 64'(first), 64'hCAFE_0001);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10 released", 64'(rsp_valid), 64'd0);
    bus_read(2'd1, hi);
    chk("R6 high after stall", 64'(hi), 64'h8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_tick();
    t_ext_load();
    t_split_write();
    t_coherent_read();
    t_clear_toggle();
    t_reinit();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule